// File: doc/BRIEF.md
# DC-link Capacitor Balancing State Selector

A dual three-phase multilevel inverter drives both ends of an open-winding motor from a split DC link. Most voltage vectors can be produced by more than one switching state. These redundant states load the series DC-link capacitors differently. This block picks which state to apply, once per sampling period. It is given the location index of the commanded voltage vector. Its output is the chosen switching state, written as six signed pole levels: three for each inverter. Every state it can emit has zero common-mode voltage on each inverter.

In open loop, a location that has two candidate states uses them on alternate sampling periods. The two candidates push the capacitor charge in opposite directions, so the charge cancels over two periods. In closed loop, two three-way comparisons are used:

- the outer comparison, top capacitor against bottom capacitor;
- the inner comparison, between the two middle capacitors.

Together they form a nine-way capacitor condition, and that condition picks a corrective state. During a speed reversal, the power flow can turn the corrective action the wrong way. An error-trend flag then swaps the block from its motoring table to its generating table, in which the corrective choices are interchanged.

Top module: `dcbal_state_sel`

## Requirements
- R1: While reset is asserted and until the first sample strobe after it, the state output is all zero. The alternation phase starts at 0 and the motoring table is selected.
- R2: The state output is registered. It changes only at a clock edge where `sampleStb` is high and holds its value on every other edge, whatever the other inputs do.
- R3: Pole k (k = 0..5) sits at bits [3k+2:3k] of `stateOut` as a 3-bit two's-complement level in the range -2..+2. Poles 0..2 belong to the first inverter and poles 3..5 to the second. The levels of each inverter sum to zero.
- R4: Location index 1 always gives the neutral state (0,0,0;0,0,0). Location index 3 always gives (2,-1,-1;1,-1,0). Neither depends on mode, comparisons or phase.
- R5: In open loop, location 0 gives state A0 = (0,0,0;-1,0,1) when the phase is 0 and state B0 = (1,0,-1;0,0,0) when the phase is 1. Location 2 gives A2 = (0,1,-1;-1,1,0) when the phase is 0 and B2 = (1,-1,0;0,-1,1) when the phase is 1. The phase toggles on every strobe and the new value applies from the next strobe.
- R6: When `closedLoopEn` is low at a strobe, the two comparison inputs and `errRising` have no effect on the state chosen.
- R7: Comparison codes are 00 Normal, 01 High and 10 Low (11 is not used and is treated as Normal). In closed loop with the motoring table, location 0 picks from its outer comparison: High gives B0, Low gives A0, and Normal falls back to alternation.
- R8: In closed loop with the motoring table, location 2 picks from its inner comparison, but only while the outer comparison is Normal. Inner Low gives A2 and inner High gives B2. Any other condition falls back to alternation.
- R9: At a strobe with `closedLoopEn` high and `errRising` high, the table flips between motoring and generating from the next strobe on. The generating table swaps the corrective choices of R7 and R8. A strobe with `closedLoopEn` low returns the block to the motoring table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sampleStb | input | 1 | One-cycle pulse marking a sampling period |
| vecIdx | input | 2 | Location index of the commanded voltage vector |
| cmpOuter | input | 2 | Outer capacitor pair comparison class |
| cmpInner | input | 2 | Inner capacitor pair comparison class |
| closedLoopEn | input | 1 | Selects closed-loop correction |
| errRising | input | 1 | Imbalance error is increasing |
| stateOut | output | 18 | Selected switching state, six signed pole levels |

## Verification
The assertions take for granted the following about the inputs:

- reset is held low at time zero;
- `sampleStb` is a synchronous pulse;
- the comparison inputs carry one of the three defined codes, so the reserved code never reaches a checked path.

The stimulus draws comparison classes only from {00, 01, 10}. It raises the strobe for exactly one cycle, with random idle gaps in between. During those gaps it changes every other input, so the hold behaviour is tested against moving inputs and not quiet ones.

// File: rtl/dcbal_pkg.sv
package dcbal_pkg;

  localparam int LEVEL_W        = 3;
  localparam int NUM_POLES      = 6;
  localparam int POLES_PER_SIDE = NUM_POLES / 2;
  localparam int STATE_W        = LEVEL_W * NUM_POLES;
  localparam int LOC_KINDS      = 4;

  typedef logic [STATE_W-1:0] poleState_t;

  typedef enum logic [1:0] {
    CMP_NORMAL = 2'b00,
    CMP_HIGH   = 2'b01,
    CMP_LOW    = 2'b10,
    CMP_RSVD   = 2'b11
  } cmpClass_e;

  typedef enum logic [1:0] {
    LOC_OUTER_PAIR = 2'd0,
    LOC_NEUTRAL    = 2'd1,
    LOC_INNER_PAIR = 2'd2,
    LOC_FIXED      = 2'd3
  } locKind_e;

  typedef struct packed {
    logic load;
    logic altPhase;
    logic regenSel;
    logic closedLoop;
  } ctrlStrobes_t;

  function automatic poleState_t packState(input int a0, input int a1, input int a2,
                                           input int b0, input int b1, input int b2);
    poleState_t s;
    int v [NUM_POLES];
    v = '{a0, a1, a2, b0, b1, b2};
    s = '0;
    for (int p = 0; p < NUM_POLES; p++) begin
      s[p*LEVEL_W +: LEVEL_W] = LEVEL_W'(v[p]);
    end
    return s;
  endfunction

  function automatic int poleLevel(input poleState_t s, input int p);
    logic signed [LEVEL_W-1:0] f;
    f = s[p*LEVEL_W +: LEVEL_W];
    return int'(f);
  endfunction

  function automatic logic sidesBalanced(input poleState_t s);
    int sumA;
    int sumB;
    sumA = 0;
    sumB = 0;
    for (int p = 0; p < POLES_PER_SIDE; p++) begin
      sumA += poleLevel(s, p);
      sumB += poleLevel(s, p + POLES_PER_SIDE);
    end
    return (sumA == 0) && (sumB == 0);
  endfunction

  function automatic logic levelsInRange(input poleState_t s);
    logic ok;
    ok = 1'b1;
    for (int p = 0; p < NUM_POLES; p++) begin
      if (poleLevel(s, p) > 2 || poleLevel(s, p) < -2) ok = 1'b0;
    end
    return ok;
  endfunction

  localparam poleState_t ST_NEUTRAL = packState(0, 0, 0, 0, 0, 0);
  localparam poleState_t ST_FIXED3  = packState(2, -1, -1, 1, -1, 0);
  localparam poleState_t ST_OUTER_A = packState(0, 0, 0, -1, 0, 1);
  localparam poleState_t ST_OUTER_B = packState(1, 0, -1, 0, 0, 0);
  localparam poleState_t ST_INNER_A = packState(0, 1, -1, -1, 1, 0);
  localparam poleState_t ST_INNER_B = packState(1, -1, 0, 0, -1, 1);

endpackage

// File: rtl/dcbal_ctrl.sv
module dcbal_ctrl
  import dcbal_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sampleStb,
  input  logic         closedLoopEn,
  input  logic         errRising,
  output ctrlStrobes_t ctrl
);

  logic altPhase;
  logic regenSel;
  logic regenNext;

  // Table selection: flip on a rising error in closed loop, home to motoring in open loop.
  always_comb begin
    regenNext = regenSel;
    if (sampleStb) begin
      if (closedLoopEn) regenNext = regenSel ^ errRising;
      else              regenNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      altPhase <= 1'b0;
      regenSel <= 1'b0;
    end else begin
      if (sampleStb) altPhase <= ~altPhase;
      regenSel <= regenNext;
    end
  end

  // Selection at a strobe uses the values held before that strobe.
  always_comb begin
    ctrl.load       = sampleStb;
    ctrl.altPhase   = altPhase;
    ctrl.regenSel   = regenSel;
    ctrl.closedLoop = closedLoopEn;
  end

endmodule

// File: rtl/dcbal_datapath.sv
module dcbal_datapath
  import dcbal_pkg::*;
#(
  parameter int LOC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     ctrl,
  input  logic [LOC_W-1:0] vecIdx,
  input  logic [1:0]       cmpOuter,
  input  logic [1:0]       cmpInner,
  output poleState_t       stateOut
);

  locKind_e   locKind;
  cmpClass_e  outerCls;
  cmpClass_e  innerCls;
  poleState_t altOuter;
  poleState_t altInner;
  poleState_t pickOuter;
  poleState_t pickInner;
  poleState_t nextState;
  poleState_t stateReg;

  always_comb begin
    locKind = locKind_e'(2'(int'(vecIdx) % LOC_KINDS));
  end

  // Open loop sees every condition as Normal.
  always_comb begin
    outerCls = ctrl.closedLoop ? cmpClass_e'(cmpOuter) : CMP_NORMAL;
    innerCls = ctrl.closedLoop ? cmpClass_e'(cmpInner) : CMP_NORMAL;
  end

  always_comb begin
    altOuter = ctrl.altPhase ? ST_OUTER_B : ST_OUTER_A;
    altInner = ctrl.altPhase ? ST_INNER_B : ST_INNER_A;
  end

  // Outer pair correction, swapped in the generating table.
  always_comb begin
    unique case (outerCls)
      CMP_HIGH: pickOuter = ctrl.regenSel ? ST_OUTER_A : ST_OUTER_B;
      CMP_LOW:  pickOuter = ctrl.regenSel ? ST_OUTER_B : ST_OUTER_A;
      default:  pickOuter = altOuter;
    endcase
  end

  // Inner pair correction, only with the outer pair in balance.
  always_comb begin
    pickInner = altInner;
    if (outerCls == CMP_NORMAL || outerCls == CMP_RSVD) begin
      unique case (innerCls)
        CMP_LOW:  pickInner = ctrl.regenSel ? ST_INNER_B : ST_INNER_A;
        CMP_HIGH: pickInner = ctrl.regenSel ? ST_INNER_A : ST_INNER_B;
        default:  pickInner = altInner;
      endcase
    end
  end

  always_comb begin
    unique case (locKind)
      LOC_OUTER_PAIR: nextState = pickOuter;
      LOC_NEUTRAL:    nextState = ST_NEUTRAL;
      LOC_INNER_PAIR: nextState = pickInner;
      default:        nextState = ST_FIXED3;
    endcase
  end

  for (genvar p = 0; p < NUM_POLES; p++) begin : g_pole
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stateReg[p*LEVEL_W +: LEVEL_W] <= '0;
      else if (ctrl.load) stateReg[p*LEVEL_W +: LEVEL_W] <= nextState[p*LEVEL_W +: LEVEL_W];
    end
  end

  assign stateOut = stateReg;

endmodule

// File: rtl/dcbal_state_sel.sv
module dcbal_state_sel
  import dcbal_pkg::*;
#(
  parameter  int NUM_LOC = 4,
  localparam int LOC_W   = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sampleStb,
  input  logic [LOC_W-1:0]   vecIdx,
  input  logic [1:0]         cmpOuter,
  input  logic [1:0]         cmpInner,
  input  logic               closedLoopEn,
  input  logic               errRising,
  output logic [STATE_W-1:0] stateOut
);

  ctrlStrobes_t ctrl;

  dcbal_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sampleStb    (sampleStb),
    .closedLoopEn (closedLoopEn),
    .errRising    (errRising),
    .ctrl         (ctrl)
  );

  dcbal_datapath #(.LOC_W(LOC_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .vecIdx   (vecIdx),
    .cmpOuter (cmpOuter),
    .cmpInner (cmpInner),
    .stateOut (stateOut)
  );

endmodule

// File: rtl/dcbal_state_sel_chk.sv
module dcbal_state_sel_chk
  import dcbal_pkg::*;
#(
  parameter int LOC_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sampleStb,
  input logic [LOC_W-1:0]   vecIdx,
  input logic               closedLoopEn,
  input logic [STATE_W-1:0] stateOut
);

  // R1: leaving reset, the output is neutral
  a_r1_reset_neutral: assert property (@(posedge clk) $rose(rst_n) |-> stateOut == '0);

  // R2: no strobe, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleStb |=> $stable(stateOut));

  // R3: levels in range and zero common mode on each inverter
  a_r3_levels: assert property (@(posedge clk) disable iff (!rst_n)
    levelsInRange(stateOut));
  a_r3_zero_cm: assert property (@(posedge clk) disable iff (!rst_n)
    sidesBalanced(stateOut));

  // R4: neutral location
  a_r4_neutral_loc: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && int'(vecIdx) == 1) |=> stateOut == ST_NEUTRAL);

  // R5: open-loop outer pair location uses only its two candidates
  a_r5_outer_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && int'(vecIdx) == 0 && !closedLoopEn) |=>
      (stateOut == ST_OUTER_A || stateOut == ST_OUTER_B));

  // R5: open-loop inner pair location uses only its two candidates
  a_r5_inner_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && int'(vecIdx) == 2 && !closedLoopEn) |=>
      (stateOut == ST_INNER_A || stateOut == ST_INNER_B));

endmodule

bind dcbal_state_sel dcbal_state_sel_chk #(.LOC_W(LOC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sampleStb    (sampleStb),
  .vecIdx       (vecIdx),
  .closedLoopEn (closedLoopEn),
  .stateOut     (stateOut)
);

// File: tb/dcbal_state_sel_tb.sv
module dcbal_state_sel_tb;

  logic        clk;
  logic        rst_n;
  logic        sampleStb;
  logic [1:0]  vecIdx;
  logic [1:0]  cmpOuter;
  logic [1:0]  cmpInner;
  logic        closedLoopEn;
  logic        errRising;
  logic [17:0] stateOut;

  int checks;
  int errors;
  bit mAlt;
  bit mRegen;
  logic [17:0] lastExp;
  bit done;

  dcbal_state_sel u_dut (
    .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb), .vecIdx(vecIdx),
    .cmpOuter(cmpOuter), .cmpInner(cmpInner), .closedLoopEn(closedLoopEn),
    .errRising(errRising), .stateOut(stateOut)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [17:0] mk(int a0, int a1, int a2, int b0, int b1, int b2);
    return {3'(b2), 3'(b1), 3'(b0), 3'(a2), 3'(a1), 3'(a0)};
  endfunction

  function automatic logic [17:0] expState(int loc, bit cl, logic [1:0] co, logic [1:0] ci,
                                           bit alt, bit regen);
    logic [17:0] oA, oB, iA, iB;
    logic [1:0] eo, ei;
    oA = mk(0, 0, 0, -1, 0, 1);
    oB = mk(1, 0, -1, 0, 0, 0);
    iA = mk(0, 1, -1, -1, 1, 0);
    iB = mk(1, -1, 0, 0, -1, 1);
    eo = cl ? co : 2'b00;
    ei = cl ? ci : 2'b00;
    case (loc)
      1: return mk(0, 0, 0, 0, 0, 0);
      3: return mk(2, -1, -1, 1, -1, 0);
      0: begin
        if (eo == 2'b01) return regen ? oA : oB;
        if (eo == 2'b10) return regen ? oB : oA;
        return alt ? oB : oA;
      end
      default: begin
        if (eo == 2'b00 && ei == 2'b10) return regen ? iB : iA;
        if (eo == 2'b00 && ei == 2'b01) return regen ? iA : iB;
        return alt ? iB : iA;
      end
    endcase
  endfunction

  task automatic check(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One strobe with given inputs; model updates after the expected value is formed.
  task automatic strobe(string req, int loc, bit cl, logic [1:0] co, logic [1:0] ci, bit er);
    logic [17:0] e;
    @(negedge clk);
    vecIdx = 2'(loc); closedLoopEn = cl; cmpOuter = co; cmpInner = ci; errRising = er;
    sampleStb = 1'b1;
    e = expState(loc, cl, co, ci, mAlt, mRegen);
    mAlt = ~mAlt;
    mRegen = cl ? (mRegen ^ er) : 1'b0;
    @(negedge clk);
    sampleStb = 1'b0;
    check(req, stateOut, e);
    lastExp = e;
  endtask

  task automatic idleScramble(int n);
    for (int k = 0; k < n; k++) begin
      vecIdx = 2'($urandom_range(0, 3));
      cmpOuter = 2'($urandom_range(0, 2));
      cmpInner = 2'($urandom_range(0, 2));
      closedLoopEn = 1'($urandom_range(0, 1));
      errRising = 1'($urandom_range(0, 1));
      @(negedge clk);
      check("R2 hold", stateOut, lastExp);
    end
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 150000 && !done; wd++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; sampleStb = 1'b0; vecIdx = 2'd2; cmpOuter = 2'b01; cmpInner = 2'b10;
    closedLoopEn = 1'b1; errRising = 1'b1;
    mAlt = 0; mRegen = 0; lastExp = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", stateOut, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset no strobe", stateOut, '0);
    idleScramble(3);

    // R5 open-loop alternation at both pair locations
    strobe("R5 outer phase0", 0, 0, 2'b00, 2'b00, 0);
    strobe("R5 outer phase1", 0, 0, 2'b00, 2'b00, 0);
    strobe("R5 inner phase0", 2, 0, 2'b00, 2'b00, 0);
    strobe("R5 inner phase1", 2, 0, 2'b00, 2'b00, 0);
    // R6 open loop ignores comparisons and error trend
    strobe("R6 ignore cmp", 0, 0, 2'b01, 2'b10, 1);
    strobe("R6 ignore cmp", 2, 0, 2'b00, 2'b01, 1);
    // R4 fixed locations
    strobe("R4 neutral", 1, 1, 2'b01, 2'b01, 0);
    strobe("R4 fixed3", 3, 1, 2'b10, 2'b10, 0);
    // R7 outer correction, motoring
    strobe("R7 outer high", 0, 1, 2'b01, 2'b00, 0);
    strobe("R7 outer low", 0, 1, 2'b10, 2'b00, 0);
    strobe("R7 outer normal alt", 0, 1, 2'b00, 2'b10, 0);
    // R8 inner correction, motoring
    strobe("R8 inner low", 2, 1, 2'b00, 2'b10, 0);
    strobe("R8 inner high", 2, 1, 2'b00, 2'b01, 0);
    strobe("R8 outer off-normal alt", 2, 1, 2'b01, 2'b10, 0);
    // R9 flip to generating, then swapped choices
    strobe("R9 flip strobe", 1, 1, 2'b00, 2'b00, 1);
    strobe("R9 gen inner low", 2, 1, 2'b00, 2'b10, 0);
    strobe("R9 gen outer high", 0, 1, 2'b01, 2'b00, 0);
    strobe("R9 open loop home", 3, 0, 2'b00, 2'b00, 0);
    strobe("R9 motoring again", 0, 1, 2'b01, 2'b00, 0);
    idleScramble(2);
    // R3 bit layout: pole 0 at bits [2:0]
    strobe("R3 layout", 3, 0, 2'b00, 2'b00, 0);
    check("R3 pole0 field", {15'd0, stateOut[2:0]}, {15'd0, 3'sd2});
    check("R3 pole5 field", {15'd0, stateOut[17:15]}, {15'd0, 3'b000});

    for (int n = 0; n < 1500; n++) begin
      strobe("R5-R9 random", int'($urandom_range(0, 3)), 1'($urandom_range(0, 3) != 0),
             2'($urandom_range(0, 2)), 2'($urandom_range(0, 2)),
             1'($urandom_range(0, 7) == 0));
      idleScramble(int'($urandom_range(0, 3)));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule